// File: doc/BRIEF.md
# Page-Write Memory Host Bus Front-End

This block is the host-side bus interface of a byte-wide page-write nonvolatile memory model. The host drives three active-low strobes (chip select, output enable and write enable) with no relation to the system clock. An address bus and a data bus come in alongside them. The block brings all of these into a fast system clock domain. From them it produces three things: a drive enable for the tri-state data bus, a read address for the memory array, and one byte-load event per completed write strobe. Each load event carries its own address and data.

A write is the span during which chip select and write enable are both low while output enable is high. The address is taken at the start of that span, which is the later of the two falling edges. The data is taken at its end, which is the earlier of the two rising edges. While the write controller reports that an internal page write or chip erase is running, reads no longer return array contents. They return a status byte with a data-polling bit and a toggle bit.

Top module: `pbus_front`

## Requirements
- R1: `dq_oe` is 1 exactly when the synchronized chip select and output enable were both low; otherwise it is 0 and `dq_out` is all zeros, so the data bus is released.
- R2: While chip select is high, toggling output enable or write enable produces no load event and no bus drive.
- R3: `load_addr` carries the address present at the start of the write span (the later of the two falling edges). Address changes later in the span are ignored.
- R4: Each completed write span produces exactly one `load_stb` pulse of one cycle, with `load_data` equal to the data present at the end of the span (the earlier of the two rising edges).
- R5: A write is not recognized while output enable is low. If output enable falls during a write span, that span is dropped without a load event.
- R6: When neither busy input is set, `dq_out` equals `array_rdata`, and `rd_addr` follows the synchronized address.
- R7: While `busy_write` is set and `busy_erase` is clear, a read returns a status byte. Bit 7 is the complement of bit 7 of the most recently loaded byte, bit 6 is the toggle bit, and bits 5..0 are zero.
- R8: The toggle bit inverts at the start of each read while busy, and is cleared whenever neither busy input is set. The first status read of a busy period therefore shows bit 6 = 1, the next shows 0.
- R9: While `busy_erase` is set, whatever the state of `busy_write`, a read returns bit 7 = 0, the toggle bit in bit 6, and zeros in bits 5..0.
- R10: A strobe, address or data change made before clock edge k is reflected in `dq_oe`, `rd_addr` and `load_stb` right after edge k+2: three register stages, none earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| addr_i | input | AW | Host address bus |
| data_i | input | DW | Host data bus as seen by the device |
| busy_write | input | 1 | Internal page write in progress (system clock domain) |
| busy_erase | input | 1 | Internal chip erase in progress (system clock domain) |
| array_rdata | input | DW | Array contents at `rd_addr` |
| dq_out | output | DW | Read data for the bus, zero when not driven |
| dq_oe | output | 1 | Tri-state drive enable for the data bus |
| rd_addr | output | AW | Read address toward the array |
| load_stb | output | 1 | One-cycle byte-load event |
| load_addr | output | AW | Address of the byte load |
| load_data | output | DW | Data of the byte load |

## Verification
Every strobe, address and data input passes two synchronizer flops and then one output register. The drive enable, the read address and the load event are therefore due three clock edges after the input change, and the status byte follows combinationally from the busy inputs in that same cycle. The bench keeps a queue of input snapshots taken at each rising edge and evaluates its model on the entry two edges old. It compares every output one time unit after each rising edge, so the clock edge never races the comparison. One directed check counts the edges from a strobe change to the drive enable. Further directed checks read the load event, the toggle bit and the pulse counts at points where the model says they have settled.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;

  // Strobe bundle, all active low as seen on the pins.
  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
  } strobe_t;

  // Source of the byte returned on a read.
  typedef enum logic [1:0] {
    RSRC_ARRAY = 2'd0,
    RSRC_POLL  = 2'd1,
    RSRC_ERASE = 2'd2
  } rsrc_e;

  // Erase has precedence over write when both busy flags are set.
  function automatic rsrc_e pick_rsrc(logic bsy_wr, logic bsy_er);
    if (bsy_er)      return RSRC_ERASE;
    else if (bsy_wr) return RSRC_POLL;
    else             return RSRC_ARRAY;
  endfunction

endpackage

// File: rtl/pbus_sync.sv
`timescale 1ns/1ps
module pbus_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pbus_wr_capture.sv
`timescale 1ns/1ps
module pbus_wr_capture #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          wr_lvl,
  output logic          ev_addr_latch,
  output logic          ev_data_latch,
  output logic          load_stb,
  output logic [AW-1:0] load_addr,
  output logic [DW-1:0] load_data
);

  logic          wr_now;
  logic [AW-1:0] addr_lat;
  logic [DW-1:0] data_hold;

  // Write span: select and write low, output enable high.
  assign wr_now        = !ce_s && !we_s && oe_s;
  // Start of span = later falling edge of the two strobes.
  assign ev_addr_latch = wr_now && !wr_lvl;
  // End of span = earlier rising edge; dropped if output enable fell.
  assign ev_data_latch = !wr_now && wr_lvl && oe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_lvl    <= 1'b0;
      addr_lat  <= '0;
      data_hold <= '0;
      load_stb  <= 1'b0;
      load_addr <= '0;
      load_data <= '0;
    end else begin
      wr_lvl   <= wr_now;
      load_stb <= ev_data_latch;
      if (ev_addr_latch) addr_lat  <= addr_s;
      if (wr_now)        data_hold <= data_s;
      if (ev_data_latch) begin
        load_addr <= addr_lat;
        load_data <= data_hold;
      end
    end
  end

endmodule

// File: rtl/pbus_rd_path.sv
`timescale 1ns/1ps
module pbus_rd_path
  import pbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic [AW-1:0] addr_s,
  input  logic          busy_write,
  input  logic          busy_erase,
  input  logic [DW-1:0] array_rdata,
  input  logic          load_stb,
  input  logic          load_msb,
  output logic          dq_oe,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] dq_out,
  output logic          ev_status_read
);

  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic  rd_now;
  logic  busy_any;
  logic  tog_q;
  logic  poll_q;
  rsrc_e src;

  function automatic logic [DW-1:0] status_word(rsrc_e s, logic poll, logic tog);
    logic [DW-1:0] w;
    w           = '0;
    w[TOG_BIT]  = tog;
    w[POLL_BIT] = (s == RSRC_POLL) ? ~poll : 1'b0;
    return w;
  endfunction

  assign rd_now         = !ce_s && !oe_s;
  assign busy_any       = busy_write || busy_erase;
  assign ev_status_read = rd_now && !dq_oe && busy_any;
  assign src            = pick_rsrc(busy_write, busy_erase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe   <= 1'b0;
      rd_addr <= '0;
      tog_q   <= 1'b0;
      poll_q  <= 1'b0;
    end else begin
      dq_oe   <= rd_now;
      rd_addr <= addr_s;
      if (!busy_any)          tog_q <= 1'b0;
      else if (ev_status_read) tog_q <= ~tog_q;
      if (load_stb) poll_q <= load_msb;
    end
  end

  always_comb begin
    if (!dq_oe)                dq_out = '0;
    else if (src == RSRC_ARRAY) dq_out = array_rdata;
    else                        dq_out = status_word(src, poll_q, tog_q);
  end

endmodule

// File: rtl/pbus_front.sv
`timescale 1ns/1ps
module pbus_front
  import pbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          busy_write,
  input  logic          busy_erase,
  input  logic [DW-1:0] array_rdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [AW-1:0] rd_addr,
  output logic          load_stb,
  output logic [AW-1:0] load_addr,
  output logic [DW-1:0] load_data
);

  localparam int SW = $bits(strobe_t);

  strobe_t       strb_raw;
  strobe_t       strb_s;
  logic [SW-1:0] strb_s_vec;
  logic          ce_s, oe_s, we_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  logic          wr_lvl;
  logic          ev_addr_latch;
  logic          ev_data_latch;
  logic          ev_status_read;

  assign strb_raw = '{ce: ce_n, oe: oe_n, we: we_n};

  pbus_sync #(.W(SW), .STAGES(SYNC_DEPTH), .RST_VAL({SW{1'b1}})) u_sync_strb (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s_vec)
  );
  pbus_sync #(.W(AW), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(addr_i), .q(addr_s)
  );
  pbus_sync #(.W(DW), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(data_i), .q(data_s)
  );

  assign strb_s = strb_s_vec;
  assign ce_s   = strb_s.ce;
  assign oe_s   = strb_s.oe;
  assign we_s   = strb_s.we;

  pbus_wr_capture #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .addr_s(addr_s), .data_s(data_s),
    .wr_lvl(wr_lvl), .ev_addr_latch(ev_addr_latch), .ev_data_latch(ev_data_latch),
    .load_stb(load_stb), .load_addr(load_addr), .load_data(load_data)
  );

  pbus_rd_path #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .oe_s(oe_s), .addr_s(addr_s),
    .busy_write(busy_write), .busy_erase(busy_erase),
    .array_rdata(array_rdata),
    .load_stb(load_stb), .load_msb(load_data[DW-1]),
    .dq_oe(dq_oe), .rd_addr(rd_addr), .dq_out(dq_out),
    .ev_status_read(ev_status_read)
  );

endmodule

// File: rtl/pbus_front_chk.sv
`timescale 1ns/1ps
module pbus_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_s,
  input logic          oe_s,
  input logic          wr_lvl,
  input logic          ev_status_read,
  input logic          load_stb,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic          busy_write,
  input logic          busy_erase
);

  logic busy_any;
  logic oe_d;
  logic seen_valid;
  logic last_tog;

  assign busy_any = busy_write || busy_erase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_d       <= 1'b0;
      seen_valid <= 1'b0;
      last_tog   <= 1'b0;
    end else begin
      oe_d <= dq_oe;
      if (!busy_any) seen_valid <= 1'b0;
      else if (dq_oe && !oe_d) begin
        seen_valid <= 1'b1;
        last_tog   <= dq_out[DW-2];
      end
    end
  end

  assert_drive_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_s && !oe_s));

  assert_single_load_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  assert_load_follows_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(wr_lvl));

  assert_no_read_write_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !load_stb);

  assert_status_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && busy_any) |-> (dq_out[DW-3:0] == '0));

  assert_toggle_alternates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !oe_d && busy_any && seen_valid && $past(ev_status_read)) |-> (dq_out[DW-2] != last_tog));

  assert_erase_poll_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && busy_erase) |-> !dq_out[DW-1]);

endmodule

bind pbus_front pbus_front_chk #(.DW(DW)) u_chk (.*);

// File: tb/pbus_front_test.sv
`timescale 1ns/1ps
module pbus_front_test;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic          busy_write = 1'b0, busy_erase = 1'b0;
  logic [DW-1:0] array_rdata;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [AW-1:0] rd_addr;
  logic          load_stb;
  logic [AW-1:0] load_addr;
  logic [DW-1:0] load_data;

  int checks = 0, failures = 0;
  int loads_seen = 0, drive_cycles = 0, loads_expected = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] arr_fn(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign array_rdata = arr_fn(rd_addr);

  pbus_front #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_i(addr_i), .data_i(data_i), .busy_write(busy_write), .busy_erase(busy_erase),
    .array_rdata(array_rdata), .dq_out(dq_out), .dq_oe(dq_oe), .rd_addr(rd_addr),
    .load_stb(load_stb), .load_addr(load_addr), .load_data(load_data)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic ce, oe, we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } snap_t;

  snap_t hist[$];
  bit            m_span, m_load, m_oe, m_tog, m_poll;
  logic [AW-1:0] m_alat, m_laddr, m_rdaddr;
  logic [DW-1:0] m_dhold, m_ldata;

  always @(posedge clk) begin
    if (!rst_n) begin
      snap_t idle_s;
      idle_s = '{ce: 1'b1, oe: 1'b1, we: 1'b1, a: '0, d: '0};
      hist = {};
      repeat (3) hist.push_front(idle_s);
      m_span = 0; m_load = 0; m_oe = 0; m_tog = 0; m_poll = 0;
      m_alat = '0; m_laddr = '0; m_rdaddr = '0; m_dhold = '0; m_ldata = '0;
    end else begin
      snap_t cur, s;
      bit wr_in, rd_in, bsy, ld_next, tog_next;
      cur = '{ce: ce_n, oe: oe_n, we: we_n, a: addr_i, d: data_i};
      hist.push_front(cur);
      while (hist.size() > 3) void'(hist.pop_back());
      s = hist[2];                       // value seen after two sync stages
      wr_in   = !s.ce && !s.we && s.oe;
      rd_in   = !s.ce && !s.oe;
      bsy     = busy_write || busy_erase;
      ld_next = m_span && !wr_in && s.oe;
      tog_next = !bsy ? 1'b0 : ((rd_in && !m_oe) ? !m_tog : m_tog);
      if (m_load) m_poll = m_ldata[DW-1];
      if (ld_next) begin m_laddr = m_alat; m_ldata = m_dhold; end
      if (wr_in && !m_span) m_alat = s.a;
      if (wr_in) m_dhold = s.d;
      m_load = ld_next; m_span = wr_in; m_oe = rd_in; m_rdaddr = s.a; m_tog = tog_next;
    end
    #1;
    if (rst_n && !finished) begin
      logic [DW-1:0] exp_q;
      string tag;
      if (load_stb) loads_seen++;
      if (dq_oe) drive_cycles++;
      check("R4", "load_stb", load_stb, m_load);
      if (m_load) begin
        check("R3", "load_addr", load_addr, m_laddr);
        check("R4", "load_data", load_data, m_ldata);
      end
      check("R1", "dq_oe", dq_oe, m_oe);
      check("R6", "rd_addr", rd_addr, m_rdaddr);
      if (!m_oe) begin exp_q = '0; tag = "R1"; end
      else if (busy_erase) begin exp_q = {1'b0, m_tog, 6'b0}; tag = "R9"; end
      else if (busy_write) begin exp_q = {!m_poll, m_tog, 6'b0}; tag = "R7"; end
      else begin exp_q = arr_fn(m_rdaddr); tag = "R6"; end
      check(tag, "dq_out", dq_out, exp_q);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d, bit we_first, bit ce_ends);
    @(negedge clk);
    addr_i = a; data_i = ~d; oe_n = 1'b1;
    if (we_first) we_n = 1'b0; else ce_n = 1'b0;
    idle(2);
    ce_n = 1'b0; we_n = 1'b0;
    idle(5);
    addr_i = ~a; data_i = d;            // late address is ignored, late data is kept
    idle(5);
    if (ce_ends) ce_n = 1'b1; else we_n = 1'b1;
    idle(2);
    ce_n = 1'b1; we_n = 1'b1;
    idle(5);
    loads_expected++;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] q);
    @(negedge clk);
    addr_i = a; ce_n = 1'b0; oe_n = 1'b0;
    idle(5);
    q = dq_out;
    oe_n = 1'b1; ce_n = 1'b1;
    idle(5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q1, q2;
    int base_loads, base_drive;
    idle(5);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", "reset dq_oe", dq_oe, 0);
    check("R4", "reset load_stb", load_stb, 0);

    // R3/R4: the four strobe orderings
    bus_write(16'h1234, 8'hA5, 0, 0);
    check("R3", "held load_addr", load_addr, 16'h1234);
    check("R4", "held load_data", load_data, 8'hA5);
    bus_write(16'h0081, 8'h5A, 1, 0);
    bus_write(16'hFF00, 8'h0F, 0, 1);
    bus_write(16'h7F7F, 8'h80, 1, 1);
    check("R3", "held load_addr", load_addr, 16'h7F7F);

    // R6: array reads
    bus_read(16'h0102, q1);
    check("R6", "array read", q1, arr_fn(16'h0102));
    bus_read(16'hBEEF, q1);
    check("R6", "array read", q1, arr_fn(16'hBEEF));

    // R10: latency from strobe change to drive enable
    @(negedge clk); addr_i = 16'h0042; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk); #2; check("R10", "dq_oe after 1 edge", dq_oe, 0);
    @(posedge clk); #2; check("R10", "dq_oe after 2 edges", dq_oe, 0);
    @(posedge clk); #2; check("R10", "dq_oe after 3 edges", dq_oe, 1);
    @(negedge clk); oe_n = 1'b1; ce_n = 1'b1;
    idle(5);

    // R5: write with output enable low, and output enable falling mid-span
    base_loads = loads_seen;
    @(negedge clk); oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; data_i = 8'h11;
    idle(6);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    idle(5);
    ce_n = 1'b0; we_n = 1'b0;
    idle(5);
    oe_n = 1'b0;
    idle(3);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    idle(6);
    check("R5", "loads while output enable low", loads_seen, base_loads);

    // R2: chip select high blocks everything
    base_loads = loads_seen; base_drive = drive_cycles;
    @(negedge clk); oe_n = 1'b0; idle(5); oe_n = 1'b1;
    we_n = 1'b0; idle(5); we_n = 1'b1; idle(5);
    check("R2", "loads while deselected", loads_seen, base_loads);
    check("R2", "drive while deselected", drive_cycles, base_drive);

    // R7/R8: write busy, last loaded byte was 8'h80
    @(negedge clk); busy_write = 1'b1;
    bus_read(16'h0003, q1);
    bus_read(16'h0003, q2);
    check("R7", "poll bit", q1[7], 0);
    check("R7", "status low bits", q1[5:0], 0);
    check("R8", "first toggle", q1[6], 1);
    check("R8", "second toggle", q2[6], 0);
    @(negedge clk); busy_write = 1'b0;
    idle(2);
    bus_write(16'h0200, 8'h3E, 0, 0);
    @(negedge clk); busy_write = 1'b1;
    bus_read(16'h0005, q1);
    check("R7", "poll bit after new load", q1[7], 1);
    check("R8", "toggle restarts high", q1[6], 1);

    // R9: erase takes precedence
    @(negedge clk); busy_erase = 1'b1;
    bus_read(16'h0006, q1);
    bus_read(16'h0006, q2);
    check("R9", "erase poll bit", q1[7], 0);
    check("R9", "erase toggle alternates", q1[6] ^ q2[6], 1);
    @(negedge clk); busy_erase = 1'b0; busy_write = 1'b0;
    idle(2);
    bus_read(16'h0306, q1);
    check("R6", "array read after busy", q1, arr_fn(16'h0306));

    check("R4", "load pulse count", loads_seen, loads_expected);

    idle(3);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule